// File: doc/BRIEF.md
# Multi-Width Serial Bus CRC-32C Monitor

This block listens passively to a serial memory bus. It keeps a running CRC-32C over every bit that crosses the bus while chip select is low. That includes command, address, mode and data bits, in either direction. A protocol decoder sits beside the block and supplies four things:

- a sample strobe for each serial clock,
- the current lane width,
- a flag that marks dummy cycles,
- a pulse when the current command is the one that reads the CRC back.

The block never drives the bus.

On each accepted sample the checksum advances by 1, 2 or 4 bits, depending on the lane width. The read-back command works in two steps. At the end of its command byte, the value to return is frozen in a separate snapshot, so the data shifted out stays stable. When that transaction closes with chip select going high, the running register returns to all ones. Any reset source, or a soft clear that covers software reset and wake-up from the low-power states, also loads all ones.

Top module: `bus_crc_monitor`

## Requirements
- R1: While `rst` is high, `crc_o` and `snap_o` are loaded with 0xFFFFFFFF. Both outputs show that value on the cycle after a reset edge.
- R2: A sample is accepted on a clock edge where all of the following hold: `sample_i`=1, `cs_n_i`=0, `dummy_i`=0 and `crc_dis_i`=0. In single mode (`lane_mode_i`=2'b00), an accepted sample shifts `lane_i[0]` into the register. The shift is MSB-first and non-reflected, using polynomial 0x1EDC6F41: the register shifts left one place and is XORed with the polynomial when the old bit 31 XOR the new bit is 1. No final XOR is applied. `crc_o` shows the result one edge after the sample.
- R3: In dual mode (`lane_mode_i`=2'b01), one accepted sample shifts in `lane_i[1]` and then `lane_i[0]`.
- R4: In quad mode (`lane_mode_i`=2'b10, and also 2'b11), one accepted sample shifts in `lane_i[3]`, `lane_i[2]`, `lane_i[1]` and `lane_i[0]`, in that order.
- R5: A sample with `dummy_i`=1 leaves `crc_o` unchanged.
- R6: While `crc_dis_i`=1, samples leave `crc_o` unchanged.
- R7: Samples taken while `cs_n_i`=1 have no effect. If chip select rises partway through a transaction and no read-back was flagged in it, the bits already taken stay in `crc_o`.
- R8: A read-back is flagged when `rd_crc_i` is high while `cs_n_i`=0. After that, on the first edge where `cs_n_i` is seen high, `crc_o` becomes 0xFFFFFFFF. Bits sampled after `rd_crc_i` within the same transaction are still folded in until that edge.
- R9: On an edge with `rd_crc_i`=1 and `cs_n_i`=0, `snap_o` takes the value that `crc_o` takes on that same edge. `snap_o` then holds until the next such edge, a reset or a soft clear.
- R10: `soft_clr_i`=1 sets both `crc_o` and `snap_o` to 0xFFFFFFFF on the next edge, and discards any flagged read-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the sample strobe is synchronous to it |
| rst | input | 1 | Synchronous active-high reset (power-on or hardware) |
| soft_clr_i | input | 1 | Software reset or exit from a low-power state |
| cs_n_i | input | 1 | Bus chip select, active low |
| sample_i | input | 1 | One-cycle strobe per serial clock sample |
| lane_mode_i | input | 2 | 00 single, 01 dual, 10/11 quad |
| lane_i | input | 4 | Sampled data lanes |
| dummy_i | input | 1 | Current sample is a dummy cycle |
| crc_dis_i | input | 1 | 1 turns the monitor off |
| rd_crc_i | input | 1 | Decoder flags the read-back command |
| crc_o | output | 32 | Running CRC register |
| snap_o | output | 32 | Value frozen for return by the read-back |

## Verification
The bench drives lane patterns that break the lane order. A design that took the lanes LSB-first in dual or quad mode would then give a checksum that differs from the bit-serial model. Dummy and disabled samples carry data that would change the value, so a design that counted them shows a difference at once. Chip select is raised mid-transaction without a read-back to catch a design that clears on every rising edge. A read-back transaction then shifts out further data after the snapshot. This exposes two faults: a snapshot that keeps following the register, and a clear that fires before chip select rises.

// File: rtl/crc_mon_pkg.sv
package crc_mon_pkg;
  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h1EDC6F41;
  localparam logic [CRC_W-1:0] CRC_INIT = '1;

  // One MSB-first, non-reflected shift step
  function automatic logic [CRC_W-1:0] crc_shift1(input logic [CRC_W-1:0] c, input logic b);
    crc_shift1 = {c[CRC_W-2:0], 1'b0} ^ ((c[CRC_W-1] ^ b) ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/crc_chain.sv
module crc_chain
  import crc_mon_pkg::*;
#(
  parameter int unsigned NB = 4
) (
  input  logic [CRC_W-1:0] crc_i,
  input  logic [NB-1:0]    bits_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] stage [NB+1];
  assign stage[0] = crc_i;
  for (genvar k = 0; k < NB; k++) begin : g_stage
    // highest lane enters first
    assign stage[k+1] = crc_shift1(stage[k], bits_i[NB-1-k]);
  end
  assign crc_o = stage[NB];
endmodule

// File: rtl/rd_clear_ctrl.sv
module rd_clear_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic soft_clr_i,
  input  logic cs_n_i,
  input  logic rd_req_i,
  output logic clr_fire_o
);
  logic cs_q;
  logic armed_q;

  assign clr_fire_o = armed_q && cs_n_i && !cs_q && !soft_clr_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q    <= 1'b1;
      armed_q <= 1'b0;
    end else begin
      cs_q <= cs_n_i;
      if (soft_clr_i || clr_fire_o) armed_q <= 1'b0;
      else if (rd_req_i && !cs_n_i) armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/bus_crc_monitor.sv
module bus_crc_monitor
  import crc_mon_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_clr_i,
  input  logic             cs_n_i,
  input  logic             sample_i,
  input  logic [1:0]       lane_mode_i,
  input  logic [LANES-1:0] lane_i,
  input  logic             dummy_i,
  input  logic             crc_dis_i,
  input  logic             rd_crc_i,
  output logic [CRC_W-1:0] crc_o,
  output logic [CRC_W-1:0] snap_o
);
  localparam int unsigned NW = $clog2(LANES) + 1;

  logic [CRC_W-1:0] crc_q, snap_q, crc_nx;
  logic [CRC_W-1:0] cand [NW];
  logic [1:0]       wsel;
  logic             upd;
  logic             clr_fire;

  for (genvar g = 0; g < NW; g++) begin : g_width
    crc_chain #(.NB(1 << g)) i_chain (
      .crc_i (crc_q),
      .bits_i(lane_i[(1 << g)-1:0]),
      .crc_o (cand[g])
    );
  end

  assign wsel   = (32'(lane_mode_i) >= NW - 1) ? 2'(NW - 1) : lane_mode_i;
  assign upd    = sample_i && !cs_n_i && !dummy_i && !crc_dis_i;
  assign crc_nx = upd ? cand[wsel] : crc_q;

  rd_clear_ctrl i_clr (
    .clk       (clk),
    .rst       (rst),
    .soft_clr_i(soft_clr_i),
    .cs_n_i    (cs_n_i),
    .rd_req_i  (rd_crc_i),
    .clr_fire_o(clr_fire)
  );

  always_ff @(posedge clk) begin
    if (rst || soft_clr_i) begin
      crc_q  <= CRC_INIT;
      snap_q <= CRC_INIT;
    end else begin
      crc_q <= clr_fire ? CRC_INIT : crc_nx;
      if (rd_crc_i && !cs_n_i) snap_q <= crc_nx;
    end
  end

  assign crc_o  = crc_q;
  assign snap_o = snap_q;
endmodule

// File: rtl/crc_mon_chk.sv
module crc_mon_chk (
  input logic        clk,
  input logic        rst,
  input logic        soft_clr_i,
  input logic        cs_n_i,
  input logic        sample_i,
  input logic        dummy_i,
  input logic        crc_dis_i,
  input logic        rd_crc_i,
  input logic        clr_fire,
  input logic [31:0] crc_o,
  input logic [31:0] snap_o
);
  AST_RESET_ONES: assert property (@(posedge clk) rst |=> (crc_o == '1 && snap_o == '1)); // R1
  AST_DUMMY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (dummy_i && !soft_clr_i && !clr_fire) |=> $stable(crc_o)); // R5
  AST_DIS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (crc_dis_i && !soft_clr_i && !clr_fire) |=> $stable(crc_o)); // R6
  AST_CS_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cs_n_i && !soft_clr_i && !clr_fire) |=> $stable(crc_o)); // R7
  AST_CLEAR_ON_CS: assert property (@(posedge clk) disable iff (rst)
    clr_fire |-> cs_n_i); // R8
  AST_CLEAR_ONES: assert property (@(posedge clk) disable iff (rst)
    clr_fire |=> crc_o == '1); // R8
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rd_crc_i && !soft_clr_i) |=> $stable(snap_o)); // R9
  AST_SOFT_ONES: assert property (@(posedge clk) disable iff (rst)
    soft_clr_i |=> (crc_o == '1 && snap_o == '1)); // R10
  AST_IDLE_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    (!sample_i && !clr_fire && !soft_clr_i) |=> $stable(crc_o)); // R2
endmodule

bind bus_crc_monitor crc_mon_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .soft_clr_i(soft_clr_i),
  .cs_n_i    (cs_n_i),
  .sample_i  (sample_i),
  .dummy_i   (dummy_i),
  .crc_dis_i (crc_dis_i),
  .rd_crc_i  (rd_crc_i),
  .clr_fire  (clr_fire),
  .crc_o     (crc_o),
  .snap_o    (snap_o)
);

// File: tb/test_bus_crc_monitor.sv
module test_bus_crc_monitor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        soft_clr_i = 1'b0;
  logic        cs_n_i = 1'b1;
  logic        sample_i = 1'b0;
  logic [1:0]  lane_mode_i = 2'b00;
  logic [3:0]  lane_i = 4'h0;
  logic        dummy_i = 1'b0;
  logic        crc_dis_i = 1'b0;
  logic        rd_crc_i = 1'b0;
  logic [31:0] crc_o, snap_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] model = 32'hFFFFFFFF;
  logic [31:0] mark;

  always #10 clk = ~clk;

  bus_crc_monitor i_bus_crc_monitor (
    .clk(clk), .rst(rst), .soft_clr_i(soft_clr_i), .cs_n_i(cs_n_i),
    .sample_i(sample_i), .lane_mode_i(lane_mode_i), .lane_i(lane_i),
    .dummy_i(dummy_i), .crc_dis_i(crc_dis_i), .rd_crc_i(rd_crc_i),
    .crc_o(crc_o), .snap_o(snap_o)
  );

  function automatic logic [31:0] ref_bit(input logic [31:0] c, input logic b);
    logic fb;
    fb = c[31] ^ b;
    ref_bit = c << 1;
    if (fb) ref_bit = ref_bit ^ 32'h1EDC6F41;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    sample_i = 0; rd_crc_i = 0; soft_clr_i = 0; dummy_i = 0;
  endtask

  // drive one sample; update model when it should count
  task automatic smp(input logic [1:0] mode, input logic [3:0] d, input logic dum = 0);
    int nb;
    @(negedge clk);
    sample_i = 1; lane_mode_i = mode; lane_i = d; dummy_i = dum; rd_crc_i = 0;
    nb = (mode == 2'b00) ? 1 : (mode == 2'b01) ? 2 : 4;
    if (!cs_n_i && !dum && !crc_dis_i)
      for (int i = nb - 1; i >= 0; i--) model = ref_bit(model, d[i]);
  endtask

  task automatic cs(input logic v);
    @(negedge clk);
    sample_i = 0; rd_crc_i = 0; cs_n_i = v;
  endtask

  task automatic t_reset();
    check("R1 crc", crc_o, 32'hFFFFFFFF);
    check("R1 snap", snap_o, 32'hFFFFFFFF);
  endtask

  task automatic t_single();
    cs(0);
    for (int i = 7; i >= 0; i--) smp(2'b00, {3'b101, 8'h9F >> i});
    idle();
    check("R2 single byte", crc_o, model);
  endtask

  task automatic t_dual();
    smp(2'b01, 4'b1110); smp(2'b01, 4'b0001); smp(2'b01, 4'b0110); smp(2'b01, 4'b1001);
    idle();
    check("R3 dual order", crc_o, model);
  endtask

  task automatic t_quad();
    smp(2'b10, 4'h1); smp(2'b10, 4'h8); smp(2'b10, 4'hC); smp(2'b10, 4'h3);
    idle();
    check("R4 quad order", crc_o, model);
    smp(2'b11, 4'h2); smp(2'b11, 4'hB);
    idle();
    check("R4 mode 11 as quad", crc_o, model);
  endtask

  task automatic t_dummy();
    mark = crc_o;
    smp(2'b10, 4'hF, 1); smp(2'b10, 4'h5, 1);
    idle();
    check("R5 dummy ignored", crc_o, mark);
    smp(2'b00, 4'h1);
    idle();
    check("R5 resume after dummy", crc_o, model);
  endtask

  task automatic t_disable();
    mark = crc_o;
    @(negedge clk); crc_dis_i = 1;
    smp(2'b10, 4'hA); smp(2'b01, 4'h2);
    idle();
    check("R6 disabled hold", crc_o, mark);
    @(negedge clk); crc_dis_i = 0;
  endtask

  task automatic t_early_cs();
    cs(1);
    mark = crc_o;
    smp(2'b10, 4'h7); smp(2'b10, 4'h9);
    idle();
    check("R7 cs high ignored", crc_o, mark);
    check("R7 aborted bits kept", crc_o, model);
  endtask

  task automatic t_read_clear();
    cs(0);
    smp(2'b00, 4'h1); smp(2'b00, 4'h0);
    @(negedge clk); sample_i = 0; rd_crc_i = 1;
    mark = model;
    idle();
    check("R9 snapshot", snap_o, mark);
    smp(2'b10, 4'hD); smp(2'b10, 4'h4);
    idle();
    check("R9 snapshot held", snap_o, mark);
    check("R8 bits after read folded", crc_o, model);
    cs(1);
    idle();
    model = 32'hFFFFFFFF;
    check("R8 clear at cs rise", crc_o, 32'hFFFFFFFF);
    check("R9 snapshot after close", snap_o, mark);
  endtask

  task automatic t_soft();
    cs(0);
    smp(2'b10, 4'h6);
    @(negedge clk); sample_i = 0; rd_crc_i = 1;
    @(negedge clk); rd_crc_i = 0; soft_clr_i = 1;
    idle();
    model = 32'hFFFFFFFF;
    check("R10 soft crc", crc_o, model);
    check("R10 soft snap", snap_o, 32'hFFFFFFFF);
    cs(1);
    cs(0);
    smp(2'b10, 4'h3);
    cs(1);
    idle();
    check("R10 pending read dropped", crc_o, model);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    t_single();
    t_dual();
    t_quad();
    t_dummy();
    t_disable();
    t_early_cs();
    t_read_clear();
    t_soft();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule